// File: doc/BRIEF.md
# Serial Block-Transfer Control Register Slave

This block is a two-wire serial slave that exposes a bank of thirteen byte-wide control registers to a bus master. It samples the bus clock and data lines with the fast system clock, finds START and STOP conditions, and answers only its own 7-bit address. It drives the data line low when it acknowledges or sends a zero and releases it otherwise.

A write frame never names a register. After the address byte the master sends two placeholder bytes, a command byte and a count byte. The slave acknowledges both and stores neither. Every byte after them goes into the bank in ascending order, starting at register 0, until STOP. A read frame has no command phase. The slave streams register 0, then 1, and so on, and stops when the master refuses a byte. Two fixed identity registers sit at the top of the bank. Register 4 carries five strap bits, captured during reset, above three writable bits.

The register contents leave the block as one flat vector. A one-cycle strobe per register marks each accepted write.

Top module: `cfgRegI2cSlave`

## Requirements
- R1: A frame whose address byte carries the `SLAVE_ADDR` parameter in its upper 7 bits is acknowledged. Bit 0 of the address byte selects the direction: 0 is a write, 1 is a read.
- R2: In a write frame, the two bytes after the address (command and count) are acknowledged and change no register.
- R3: In a write frame, the third and later bytes land in register 0, then 1, 2 and onward, one register per byte, until STOP. A register changes only in a cycle where its write strobe is high.
- R4: A read frame returns register 0 first and then each following register in ascending order, MSB first, for as long as the master acknowledges.
- R5: Registers 11 and 12 are read-only and always hold 0x05 and 0x31.
- R6: After reset the bank holds these values:
  - register 0: 0x00
  - register 1: 0xCF
  - registers 2 and 3: 0xFF
  - register 4: {strap, 3'b111}
  - register 5: 0x93
  - register 6: 0x00
  - register 7: 0x40
  - registers 8 to 10: 0x00
- R7: Register 4 bits 7:3 hold the strap input captured while reset is active, and a write changes only bits 2:0.
- R8: Write bytes that go past register 10 are acknowledged and discarded. Read bytes past register 12 return 0xFF.
- R9: A frame with any other address gets no acknowledge. The slave then ignores the bus until the next START.
- R10: When the master does not acknowledge a read byte, the slave releases the data line and stays silent until the next START. A later write frame works normally.
- R11: Each accepted write to a writable register pulses that register's bit of `wrStrobe` for exactly one cycle. The strobe never pulses for registers 11 and 12 or for indices past the bank.
- R12: The slave changes its data-line drive only after it has seen the bus clock fall, or at a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Synchronous active-low reset |
| sclIn | input | 1 | Bus clock line |
| sdaIn | input | 1 | Bus data line as seen on the wire |
| strapIn | input | 5 | Strap levels captured into register 4 bits 7:3 during reset |
| sdaOe | output | 1 | 1 pulls the data line low; 0 releases it |
| regFlat | output | 104 | Register n occupies bits 8n+7 down to 8n |
| wrStrobe | output | 13 | One-cycle write pulse per register |

## Verification
The bus lines pass through two synchronizer flops and an edge-detect flop, so the control sees a bus clock fall about three system cycles late. A received byte reaches `regFlat` and `wrStrobe` on the fourth cycle after the eighth falling edge. The acknowledge drive appears on the third. The bench drives the bus with a quarter bit of eight system cycles. It updates its register model at the rising clock edge of the acknowledge bit, sixteen cycles after that falling edge. It compares the whole bank on every clock outside that window. Read data and acknowledge levels are sampled in the middle of the high half of the bus clock, long after the slave has settled.

// File: rtl/regSlavePkg.sv
package regSlavePkg;
  localparam int BYTE_W    = 8;
  localparam int REG_COUNT = 13;
  localparam int IDX_W     = $clog2(REG_COUNT + 1);
  localparam int STRAP_W   = 5;
  localparam int LOW_W     = BYTE_W - STRAP_W;
  localparam int STRAP_REG = 4;
  localparam int ID_LO_REG = 11;
  localparam int ID_HI_REG = 12;
  localparam logic [BYTE_W-1:0] ID_LO_VAL = 8'h05;
  localparam logic [BYTE_W-1:0] ID_HI_VAL = 8'h31;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TXACK, ST_WAIT
  } slvState_t;

  // strobes from control to the register bank
  typedef struct packed {
    logic              wrEn;
    logic [IDX_W-1:0]  wrIdx;
    logic [BYTE_W-1:0] wrData;
    logic [IDX_W-1:0]  rdIdx;
  } bankCtl_t;

  function automatic logic [BYTE_W-1:0] writeMask(input int idx);
    if (idx == STRAP_REG) return {{STRAP_W{1'b0}}, {LOW_W{1'b1}}};
    if (idx == ID_LO_REG || idx == ID_HI_REG) return '0;
    return '1;
  endfunction

  function automatic logic [BYTE_W-1:0] resetValue(input int idx,
                                                   input logic [STRAP_W-1:0] strap);
    case (idx)
      1:         return 8'hCF;
      2, 3:      return 8'hFF;
      STRAP_REG: return {strap, {LOW_W{1'b1}}};
      5:         return 8'h93;
      7:         return 8'h40;
      ID_LO_REG: return ID_LO_VAL;
      ID_HI_REG: return ID_HI_VAL;
      default:   return '0;
    endcase
  endfunction
endpackage

// File: rtl/busLineSync.sv
module busLineSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev, sclS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclS     = sclPipe[STAGES-1];
  assign sdaS     = sdaPipe[STAGES-1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
endmodule

// File: rtl/slaveCtl.sv
module slaveCtl
  import regSlavePkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h52
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaS,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic [BYTE_W-1:0] rdByte,
  output bankCtl_t          bankCtl,
  output logic              sdaOe
);
  localparam logic [1:0] PH_DATA = 2'd2;
  localparam logic [3:0] BITS_PER_BYTE = 4'(BYTE_W);

  slvState_t         state;
  logic [3:0]        bitCnt;
  logic [BYTE_W-1:0] rxShift, txShift;
  logic              isAddr, readMode, masterAck;
  logic [1:0]        phase;
  logic [IDX_W-1:0]  regIdx, idxNext;
  logic              wrEnQ;
  logic [IDX_W-1:0]  wrIdxQ;
  logic [BYTE_W-1:0] wrDataQ;

  assign idxNext = (regIdx < IDX_W'(REG_COUNT)) ? regIdx + 1'b1 : regIdx;

  always_comb begin
    bankCtl.wrEn   = wrEnQ;
    bankCtl.wrIdx  = wrIdxQ;
    bankCtl.wrData = wrDataQ;
    bankCtl.rdIdx  = regIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      rxShift   <= '0;
      txShift   <= '0;
      isAddr    <= 1'b1;
      readMode  <= 1'b0;
      masterAck <= 1'b0;
      phase     <= '0;
      regIdx    <= '0;
      wrEnQ     <= 1'b0;
      wrIdxQ    <= '0;
      wrDataQ   <= '0;
      sdaOe     <= 1'b0;
    end else begin
      wrEnQ <= 1'b0;
      if (startDet) begin
        state  <= ST_RX;
        isAddr <= 1'b1;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else if (stopDet) begin
        state <= ST_IDLE;
        sdaOe <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (sclRise) begin
              rxShift <= {rxShift[BYTE_W-2:0], sdaS};
              bitCnt  <= bitCnt + 1'b1;
            end else if (sclFall && bitCnt == BITS_PER_BYTE) begin
              bitCnt <= '0;
              if (isAddr) begin
                if (rxShift[BYTE_W-1:1] == SLAVE_ADDR) begin
                  sdaOe    <= 1'b1;
                  state    <= ST_ACK;
                  readMode <= rxShift[0];
                  regIdx   <= '0;
                  phase    <= '0;
                end else begin
                  state <= ST_WAIT;
                end
              end else begin
                sdaOe <= 1'b1;
                state <= ST_ACK;
                if (phase == PH_DATA) begin
                  wrEnQ   <= (regIdx < IDX_W'(REG_COUNT));
                  wrIdxQ  <= regIdx;
                  wrDataQ <= rxShift;
                  regIdx  <= idxNext;
                end else begin
                  phase <= phase + 1'b1;
                end
              end
            end
          end
          ST_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (readMode) begin
                txShift <= rdByte;
                sdaOe   <= ~rdByte[BYTE_W-1];
                regIdx  <= idxNext;
                state   <= ST_TX;
              end else begin
                sdaOe  <= 1'b0;
                isAddr <= 1'b0;
                state  <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (sclRise) begin
              bitCnt <= bitCnt + 1'b1;
            end else if (sclFall) begin
              if (bitCnt == BITS_PER_BYTE) begin
                sdaOe  <= 1'b0;
                bitCnt <= '0;
                state  <= ST_TXACK;
              end else begin
                txShift <= {txShift[BYTE_W-2:0], 1'b0};
                sdaOe   <= ~txShift[BYTE_W-2];
              end
            end
          end
          ST_TXACK: begin
            if (sclRise) begin
              masterAck <= ~sdaS;
            end else if (sclFall) begin
              if (masterAck) begin
                txShift <= rdByte;
                sdaOe   <= ~rdByte[BYTE_W-1];
                regIdx  <= idxNext;
                state   <= ST_TX;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/regBank.sv
module regBank
  import regSlavePkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [STRAP_W-1:0]          strapIn,
  input  bankCtl_t                    bankCtl,
  output logic [BYTE_W-1:0]           rdByte,
  output logic [REG_COUNT*BYTE_W-1:0] regFlat,
  output logic [REG_COUNT-1:0]        wrStrobe
);
  logic [BYTE_W-1:0] regQ [REG_COUNT];

  for (genvar gi = 0; gi < REG_COUNT; gi++) begin : gReg
    localparam logic [BYTE_W-1:0] MASK = writeMask(gi);
    logic hit;
    assign hit = bankCtl.wrEn && (bankCtl.wrIdx == IDX_W'(gi));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        regQ[gi]     <= resetValue(gi, strapIn);
        wrStrobe[gi] <= 1'b0;
      end else begin
        wrStrobe[gi] <= hit && (MASK != '0);
        if (hit) regQ[gi] <= (regQ[gi] & ~MASK) | (bankCtl.wrData & MASK);
      end
    end

    assign regFlat[gi*BYTE_W +: BYTE_W] = regQ[gi];
  end

  always_comb begin
    rdByte = '1;
    for (int i = 0; i < REG_COUNT; i++)
      if (bankCtl.rdIdx == IDX_W'(i)) rdByte = regQ[i];
  end
endmodule

// File: rtl/cfgRegI2cSlave.sv
module cfgRegI2cSlave
  import regSlavePkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h52,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sclIn,
  input  logic                        sdaIn,
  input  logic [STRAP_W-1:0]          strapIn,
  output logic                        sdaOe,
  output logic [REG_COUNT*BYTE_W-1:0] regFlat,
  output logic [REG_COUNT-1:0]        wrStrobe
);
  logic sdaS, sclRise, sclFall, startDet, stopDet;
  logic [BYTE_W-1:0] rdByte;
  bankCtl_t bankCtl;

  busLineSync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .sdaS(sdaS),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet)
  );

  slaveCtl #(.SLAVE_ADDR(SLAVE_ADDR)) ctl_i (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .rdByte(rdByte),
    .bankCtl(bankCtl), .sdaOe(sdaOe)
  );

  regBank bank_i (
    .clk(clk), .rstN(rstN), .strapIn(strapIn), .bankCtl(bankCtl),
    .rdByte(rdByte), .regFlat(regFlat), .wrStrobe(wrStrobe)
  );
endmodule

// File: rtl/cfgRegI2cSlaveChk.sv
module cfgRegI2cSlaveChk
  import regSlavePkg::*;
(
  input logic                        clk,
  input logic                        rstN,
  input logic                        sdaOe,
  input logic [REG_COUNT*BYTE_W-1:0] regFlat,
  input logic [REG_COUNT-1:0]        wrStrobe,
  input logic                        sclFall,
  input logic                        startDet,
  input logic                        stopDet
);
  // R11: at most one register strobed at a time, never two cycles in a row
  assert_strobe_onehot_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrStrobe));
  assert_strobe_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe != '0) |=> (wrStrobe == '0));

  // R7: strap field of register 4 never moves outside reset
  assert_strap_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    $stable(regFlat[STRAP_REG*BYTE_W+LOW_W +: STRAP_W]));

  // R12: drive changes only follow a detected clock fall, START or STOP
  assert_sda_after_fall_R12: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> ($past(sclFall) || $past(startDet) || $past(stopDet)));

  // R3: a register only changes together with its own strobe
  for (genvar gi = 0; gi < REG_COUNT; gi++) begin : gWr
    assert_reg_write_R3: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(regFlat[gi*BYTE_W +: BYTE_W]) |-> wrStrobe[gi]);
  end
endmodule

bind cfgRegI2cSlave cfgRegI2cSlaveChk chk_i (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .regFlat(regFlat), .wrStrobe(wrStrobe),
  .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet)
);

// File: tb/cfgRegI2cSlave_tb_top.sv
`timescale 1ns/1ps
module cfgRegI2cSlave_tb_top;
  localparam int NREG = 13;
  localparam int Q = 8;
  localparam logic [6:0] ADDR = 7'h52;
  localparam logic [4:0] STRAP = 5'b10110;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic sdaLine, sdaOe;
  logic [NREG*8-1:0] regFlat;
  logic [NREG-1:0] wrStrobe;

  always #2 clk = ~clk;
  assign sdaLine = sdaDrv & ~sdaOe;

  cfgRegI2cSlave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine), .strapIn(STRAP),
    .sdaOe(sdaOe), .regFlat(regFlat), .wrStrobe(wrStrobe)
  );

  int errors = 0, checks = 0;
  bit settle = 1'b0, rstDone = 1'b0, done = 1'b0;
  logic [7:0] expRegs [NREG];
  int expStrobe [NREG];
  int seenStrobe [NREG];
  int sclHighCnt = 0;
  logic prevOe = 1'b0;
  int modelFails = 0;

  function automatic logic [7:0] maskOf(input int i);
    if (i == 4) return 8'h07;
    if (i == 11 || i == 12) return 8'h00;
    return 8'hFF;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // whole-bank model compare on every clock outside the write settle window (R3 R6)
  always @(negedge clk) begin
    if (rstDone && !settle) begin
      for (int i = 0; i < NREG; i++) begin
        checks++;
        if (regFlat[i*8 +: 8] !== expRegs[i]) begin
          errors++;
          if (modelFails < 20)
            $display("FAIL R3 reg%0d actual=0x%0h expected=0x%0h", i, regFlat[i*8 +: 8], expRegs[i]);
          modelFails++;
        end
      end
    end
    if (rstDone) begin
      for (int i = 0; i < NREG; i++) if (wrStrobe[i]) seenStrobe[i]++;
      if (sdaOe !== prevOe) begin
        check(!(sclDrv && sclHighCnt >= 4), "R12 drive change while clock high", sclHighCnt, 0);
      end
    end
    prevOe = sdaOe;
    sclHighCnt = sclDrv ? sclHighCnt + 1 : 0;
  end

  task automatic waitQ(input int n);
    repeat (n * Q) @(posedge clk);
    #1;
  endtask

  task automatic startCond();
    sdaDrv = 1'b1; waitQ(1); sclDrv = 1'b1; waitQ(1);
    sdaDrv = 1'b0; waitQ(1); sclDrv = 1'b0; waitQ(1);
  endtask

  task automatic stopCond();
    sdaDrv = 1'b0; waitQ(1); sclDrv = 1'b1; waitQ(1);
    sdaDrv = 1'b1; waitQ(2);
  endtask

  task automatic sendByte(input logic [7:0] d, input int mIdx, output bit acked);
    logic [7:0] m;
    for (int b = 7; b >= 0; b--) begin
      sdaDrv = d[b]; waitQ(1); sclDrv = 1'b1; waitQ(2);
      if (b == 0) settle = 1'b1;
      sclDrv = 1'b0; waitQ(1);
    end
    sdaDrv = 1'b1; waitQ(1); sclDrv = 1'b1;
    if (mIdx >= 0 && mIdx < NREG) begin
      m = maskOf(mIdx);
      if (m != 8'h00) begin
        expRegs[mIdx] = (expRegs[mIdx] & ~m) | (d & m);
        expStrobe[mIdx]++;
      end
    end
    settle = 1'b0;
    waitQ(1); acked = !sdaLine; waitQ(1); sclDrv = 1'b0; waitQ(1);
  endtask

  task automatic readByte(input bit nack, output logic [7:0] d);
    for (int b = 7; b >= 0; b--) begin
      sdaDrv = 1'b1; waitQ(1); sclDrv = 1'b1; waitQ(1);
      d[b] = sdaLine; waitQ(1); sclDrv = 1'b0; waitQ(1);
    end
    sdaDrv = nack; waitQ(1); sclDrv = 1'b1; waitQ(1);
    if (nack) check(sdaLine === 1'b1, "R10 line released at refused byte", sdaLine, 1);
    waitQ(1); sclDrv = 1'b0; waitQ(1);
  endtask

  task automatic writeFrame(input logic [6:0] addr, input int n, input logic [7:0] data [16],
                            input bit expAck);
    bit ack;
    startCond();
    sendByte({addr, 1'b0}, -1, ack);
    check(ack == expAck, expAck ? "R1 address acknowledge" : "R9 foreign address not acknowledged", ack, expAck);
    sendByte(8'hA5, -1, ack);
    check(ack == expAck, "R2 command byte acknowledge", ack, expAck);
    sendByte(8'h3E, -1, ack);
    check(ack == expAck, "R2 count byte acknowledge", ack, expAck);
    for (int k = 0; k < n; k++) begin
      sendByte(data[k], expAck ? k : -1, ack);
      check(ack == expAck, (k > 10) ? "R8 write past bank acknowledged" : "R3 data byte acknowledge", ack, expAck);
    end
    stopCond();
  endtask

  task automatic readFrame(input logic [6:0] addr, input int n, input bit expAck);
    bit ack;
    logic [7:0] d, e;
    startCond();
    sendByte({addr, 1'b1}, -1, ack);
    check(ack == expAck, expAck ? "R1 read address acknowledge" : "R9 foreign read address", ack, expAck);
    if (expAck) begin
      for (int k = 0; k < n; k++) begin
        readByte(k == n - 1, d);
        e = (k < NREG) ? expRegs[k] : 8'hFF;
        if (k >= NREG)        check(d == e, "R8 read past bank", d, e);
        else if (k >= 11)     check(d == e, "R5 identity register read", d, e);
        else                  check(d == e, "R4 read stream order", d, e);
      end
    end
    stopCond();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] buffer [16];
    for (int i = 0; i < NREG; i++) begin
      expStrobe[i] = 0; seenStrobe[i] = 0; expRegs[i] = 8'h00;
    end
    expRegs[1] = 8'hCF; expRegs[2] = 8'hFF; expRegs[3] = 8'hFF;
    expRegs[4] = {STRAP, 3'b111}; expRegs[5] = 8'h93; expRegs[7] = 8'h40;
    expRegs[11] = 8'h05; expRegs[12] = 8'h31;

    repeat (6) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
    rstDone = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NREG; i++)
      check(regFlat[i*8 +: 8] == expRegs[i], "R6 reset value", regFlat[i*8 +: 8], expRegs[i]);
    check(regFlat[39:35] == STRAP, "R7 strap captured", regFlat[39:35], STRAP);
    check(sdaOe == 1'b0, "R6 line released after reset", sdaOe, 0);
    #1;

    // short write: command/count ignored, data from register 0
    buffer[0] = 8'h12; buffer[1] = 8'h34; buffer[2] = 8'h56;
    writeFrame(ADDR, 3, buffer, 1'b1);
    @(negedge clk);
    check(regFlat[7:0] == 8'h12, "R2 R3 first data byte lands in register 0", regFlat[7:0], 8'h12);
    check(regFlat[23:16] == 8'h56, "R3 third data byte lands in register 2", regFlat[23:16], 8'h56);
    #1;

    // full write running past the bank
    for (int k = 0; k < 15; k++) buffer[k] = 8'(8'h21 + k * 8'h17);
    buffer[4] = 8'hF8;
    writeFrame(ADDR, 15, buffer, 1'b1);
    @(negedge clk);
    check(regFlat[39:32] == {STRAP, 3'b000}, "R7 only low bits of register 4 written", regFlat[39:32], {STRAP, 3'b000});
    check(regFlat[95:88] == 8'h05, "R5 register 11 unchanged by write", regFlat[95:88], 8'h05);
    check(regFlat[103:96] == 8'h31, "R5 register 12 unchanged by write", regFlat[103:96], 8'h31);
    #1;

    // read stream past the bank
    readFrame(ADDR, 15, 1'b1);
    @(negedge clk); check(sdaOe == 1'b0, "R10 silent after refused byte", sdaOe, 0); #1;

    // foreign address, write then read
    for (int k = 0; k < 16; k++) buffer[k] = 8'h00;
    writeFrame(ADDR ^ 7'h01, 2, buffer, 1'b0);
    readFrame(ADDR ^ 7'h40, 1, 1'b0);

    // short read refused after two bytes, then a new write
    readFrame(ADDR, 2, 1'b1);
    buffer[0] = 8'h3C;
    writeFrame(ADDR, 1, buffer, 1'b1);
    @(negedge clk);
    check(regFlat[7:0] == 8'h3C, "R10 write after refused read", regFlat[7:0], 8'h3C);
    for (int i = 0; i < NREG; i++)
      check(seenStrobe[i] == expStrobe[i], "R11 strobe count per register", seenStrobe[i], expStrobe[i]);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule